// File: doc/BRIEF.md
# PWM Action Qualifier Output Stage

This block turns time-base events into two pulse-width-modulated output levels, A and B. A time-base counter outside the block supplies its current value, its counting direction, a tick strobe and two flags that mark the zero and period points of the count. Inside the block, each output has its own compare register and comparator. Each output also has its own action-control word. The word assigns an action to each event that can affect that output.

Every action is a 2-bit code that leaves the output alone, drives it low, drives it high or toggles it. Output polarity is not a separate inverter. It is chosen through the codes. The normal waveform sets the output high at zero and at period and clears it on the compare match. The inverted waveform swaps those levels. Software loads the two action words and the two compare values through one small write port. When several events land on the same tick, a fixed priority decides which action is applied.

Top module: `pwm_action_out`

## Requirements
- R1: After reset both outputs are low, and all action words and compare values read as zero. In that state a tick carrying every event leaves both outputs low.
- R2: The action code values are as follows: 2'b00 leaves the output unchanged, 2'b01 drives it low, 2'b10 drives it high and 2'b11 inverts it.
- R3: In an action word, bits [1:0] hold the zero-event code and bits [3:2] hold the period-event code. Output A takes its compare code from bits [5:4] and ignores bits [9:8]. Output B takes its compare code from bits [9:8] and ignores bits [5:4].
- R4: A compare event fires only on a tick where the counter equals that output's compare value and the direction input is high (counting up). An equal count while counting down has no effect.
- R5: On a tick with several events, an output applies the code of the highest-priority event whose code is non-zero. The priority order is compare first, then period, then zero. An event whose code is 2'b00 does not mask a lower-priority event.
- R6: When tick is low, both outputs hold their level, whatever the event inputs are.
- R7: On a write, wr_sel selects the target: 0 is action word A, 1 is action word B, 2 is compare A and 3 is compare B. A written value first takes effect on the cycle after the write.
- R8: Outputs are registered. A tick sampled at a rising clock edge changes the output right after that edge and not before it.
- R9: The action word 16'h001A gives normal polarity on output A. The action word 16'h0205 gives inverted polarity on output B. Both outputs share the period event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | The time-base counter advanced this cycle |
| cnt | input | CNT_W | Current counter value |
| cnt_up | input | 1 | Counter direction: 1 = up |
| at_zero | input | 1 | The counter is at zero on this tick |
| at_period | input | 1 | The counter is at the shared period on this tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 action A, 1 action B, 2 compare A, 3 compare B |
| wr_data | input | CTL_W | Write data |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
A table of ticks runs one full up-count period and then a down-count stretch, with output A in normal polarity and output B in inverted polarity. This separates compare matches from period and zero events, and it shows that direction gating works. Rows that stack a compare match on the same tick as a zero or period event separate the priority order from a plain last-event-wins rule. Directed cases cover:
- the hold on ticks without a strobe;
- toggling;
- ignored fields in the action word;
- a compare code of zero that must not mask a lower-priority event;
- a compare write that lands on the same cycle as a matching count, which shows the one-cycle load latency.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
    localparam int CTL_W    = 16;
    localparam int CODE_W   = 2;
    localparam int ZERO_LSB = 0;
    localparam int PRD_LSB  = 2;
    localparam int CMPA_LSB = 4;
    localparam int CMPB_LSB = 8;

    typedef enum logic [CODE_W-1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } act_code_e;

    // Decoded per-output action set: only the fields this output uses.
    typedef struct packed {
        act_code_e on_cmp;
        act_code_e on_prd;
        act_code_e on_zero;
    } act_set_t;

    function automatic logic apply_code(act_code_e code, logic cur);
        case (code)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CTL_W-1:0] wr_data,
    output act_set_t         act_a,
    output act_set_t         act_b,
    output logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cmp_b
);
    localparam logic [1:0] SEL_ACT_A = 2'd0;
    localparam logic [1:0] SEL_ACT_B = 2'd1;
    localparam logic [1:0] SEL_CMP_A = 2'd2;

    typedef struct packed {
        act_set_t         a;
        act_set_t         b;
        logic [CNT_W-1:0] ca;
        logic [CNT_W-1:0] cb;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_ACT_A: begin
                    regs_d.a.on_zero = act_code_e'(wr_data[ZERO_LSB +: CODE_W]);
                    regs_d.a.on_prd  = act_code_e'(wr_data[PRD_LSB  +: CODE_W]);
                    regs_d.a.on_cmp  = act_code_e'(wr_data[CMPA_LSB +: CODE_W]);
                end
                SEL_ACT_B: begin
                    regs_d.b.on_zero = act_code_e'(wr_data[ZERO_LSB +: CODE_W]);
                    regs_d.b.on_prd  = act_code_e'(wr_data[PRD_LSB  +: CODE_W]);
                    regs_d.b.on_cmp  = act_code_e'(wr_data[CMPB_LSB +: CODE_W]);
                end
                SEL_CMP_A: regs_d.ca = wr_data[CNT_W-1:0];
                default:   regs_d.cb = wr_data[CNT_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign act_a = regs_q.a;
    assign act_b = regs_q.b;
    assign cmp_a = regs_q.ca;
    assign cmp_b = regs_q.cb;

    // R7: a compare write is visible on the next cycle
    assert_cmp_a_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CMP_A) |=> (cmp_a == $past(wr_data[CNT_W-1:0])));
    assert_cmp_a_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cmp_a));
endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_up,
    input  logic             at_zero,
    input  logic             at_period,
    input  act_set_t         acts,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             pwm
);
    typedef struct packed {
        logic lvl;
    } chan_t;

    chan_t     chan_d, chan_q;
    logic      hit_cmp;
    act_code_e chosen;

    always_comb begin
        hit_cmp = tick && cnt_up && (cnt == cmp_val);
        chosen  = ACT_KEEP;
        // lowest priority first; later non-zero codes override
        if (tick && at_zero   && acts.on_zero != ACT_KEEP) chosen = acts.on_zero;
        if (tick && at_period && acts.on_prd  != ACT_KEEP) chosen = acts.on_prd;
        if (hit_cmp           && acts.on_cmp  != ACT_KEEP) chosen = acts.on_cmp;
        chan_d.lvl = apply_code(chosen, chan_q.lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign pwm = chan_q.lvl;

    // R6: no tick, no change
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pwm));
    // R4: an equal count while counting down is not an event
    assert_down_no_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_up && !at_zero && !at_period) |=> $stable(pwm));
    // R5: a compare match with a set-high code wins over any other event
    assert_cmp_high_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cmp && acts.on_cmp == ACT_HIGH) |=> pwm);
    assert_cmp_low_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cmp && acts.on_cmp == ACT_LOW) |=> !pwm);
    // R2: toggle on a lone zero event
    assert_zero_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_zero && !at_period && !hit_cmp && acts.on_zero == ACT_FLIP)
        |=> (pwm != $past(pwm)));
endmodule

// File: rtl/pwm_action_out.sv
module pwm_action_out
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_up,
    input  logic             at_zero,
    input  logic             at_period,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CTL_W-1:0] wr_data,
    output logic             pwm_a,
    output logic             pwm_b
);
    localparam int N_OUT = 2;

    act_set_t         acts [N_OUT];
    logic [CNT_W-1:0] cmps [N_OUT];
    logic             lvls [N_OUT];

    pwm_aq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .act_a   (acts[0]),
        .act_b   (acts[1]),
        .cmp_a   (cmps[0]),
        .cmp_b   (cmps[1])
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_chan
        pwm_aq_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cnt       (cnt),
            .cnt_up    (cnt_up),
            .at_zero   (at_zero),
            .at_period (at_period),
            .acts      (acts[g]),
            .cmp_val   (cmps[g]),
            .pwm       (lvls[g])
        );
    end

    assign pwm_a = lvls[0];
    assign pwm_b = lvls[1];

    // R1: outputs low while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (!pwm_a && !pwm_b);
        end
    end
endmodule

// File: tb/pwm_action_out_tb.sv
module pwm_action_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cnt = '0;
    logic        cnt_up = 1'b0;
    logic        at_zero = 1'b0;
    logic        at_period = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_action_out u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
        .at_zero(at_zero), .at_period(at_period), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // {cnt[15:0], up, zero, period, exp_a, exp_b}; A normal polarity, B inverted
    localparam logic [20:0] VEC [0:9] = '{
        {16'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {16'd3,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {16'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {16'd9,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {16'd12, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {16'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {16'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {16'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {16'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {16'd9,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic tk, input logic [15:0] c, input logic u,
                        input logic z, input logic p);
        tick = tk; cnt = c; cnt_up = u; at_zero = z; at_period = p;
        @(posedge clk); @(negedge clk);
        tick = 1'b0; at_zero = 1'b0; at_period = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pwm_a", pwm_a, 1'b0);
        chk("R1 reset pwm_b", pwm_b, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b1, 16'd0, 1'b1, 1'b1, 1'b1);   // all regs zero: no actions
        chk("R1 zero regs pwm_a", pwm_a, 1'b0);
        chk("R1 zero regs pwm_b", pwm_b, 1'b0);

        wr(2'd0, 16'h001A);                   // R9 normal polarity on A
        wr(2'd1, 16'h0205);                   // R9 inverted polarity on B
        wr(2'd2, 16'd5);
        wr(2'd3, 16'd9);
        for (int i = 0; i < 10; i++) begin
            step(1'b1, VEC[i][20:5], VEC[i][4], VEC[i][3], VEC[i][2]);
            chk($sformatf("R9/R4/R5 row %0d pwm_a", i), pwm_a, VEC[i][1]);
            chk($sformatf("R9/R4/R5 row %0d pwm_b", i), pwm_b, VEC[i][0]);
        end

        // R6: no tick holds both outputs at 1
        step(1'b0, 16'd5, 1'b1, 1'b1, 1'b1);
        chk("R6 hold pwm_a", pwm_a, 1'b1);
        chk("R6 hold pwm_b", pwm_b, 1'b1);

        // R2: toggle on zero
        wr(2'd0, 16'h0003);
        step(1'b1, 16'd3, 1'b1, 1'b1, 1'b0);
        chk("R2 toggle 1 pwm_a", pwm_a, 1'b0);
        chk("R2 low code pwm_b", pwm_b, 1'b0);
        step(1'b1, 16'd3, 1'b1, 1'b1, 1'b0);
        chk("R2 toggle 2 pwm_a", pwm_a, 1'b1);

        // R3: A ignores bits [9:8]; B ignores bits [5:4]
        wr(2'd0, 16'h0300);
        wr(2'd2, 16'd9);
        step(1'b1, 16'd9, 1'b1, 1'b0, 1'b0);
        chk("R3 A ignores [9:8]", pwm_a, 1'b1);
        chk("R3 B compare [9:8]", pwm_b, 1'b1);
        wr(2'd1, 16'h0010);
        step(1'b1, 16'd9, 1'b1, 1'b0, 1'b0);
        chk("R3 B ignores [5:4]", pwm_b, 1'b1);

        // R5: a compare code of 00 does not mask the zero event
        wr(2'd0, 16'h0001);
        step(1'b1, 16'd3, 1'b1, 1'b1, 1'b0);
        chk("R5 setup low pwm_a", pwm_a, 1'b0);
        wr(2'd0, 16'h0002);
        step(1'b1, 16'd9, 1'b1, 1'b1, 1'b0);
        chk("R5 no-mask pwm_a", pwm_a, 1'b1);

        // R7/R8: compare write and a matching count in the same cycle
        wr(2'd0, 16'h0010);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'd20;
        tick = 1'b1; cnt = 16'd20; cnt_up = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R7 old compare still used", pwm_a, 1'b1);
        tick = 1'b1; cnt = 16'd20; cnt_up = 1'b1;
        #1;
        chk("R8 no change before edge", pwm_a, 1'b1);
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
        chk("R7/R8 new compare after edge", pwm_a, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule